// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block judges a single memory access against a 64-bit segment descriptor. A request carries the descriptor, a 32-bit offset, the kind of access (read, write or execute) and the requester's current privilege level. The block reassembles the 32-bit base and the 20-bit limit from their split fields. It scales the limit when the granularity bit asks for 4 KB units. It then tests presence, the segment type, privilege and bounds, and answers with either a linear address or a fault code.

On a successful access the block also returns the descriptor with its accessed flag set, so the caller can write it back to the descriptor table. On a fault the descriptor is returned untouched. The request is registered on the clock edge where `req_valid` is high. The response is registered on the next edge and is valid for one cycle. Every cycle can take a new request.

Top module: `seg_access_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_fault`, `rsp_linear` and `rsp_desc` become zero.
- R2: A request taken on edge N (with `req_valid` high) gives `rsp_valid` high after edge N+1, for one cycle only. The next request may follow on the very next edge.
- R3: On success, `rsp_linear` is base + offset modulo 2^32. The base is bits 39:16 (low 24 bits) joined with bits 63:56 (high 8 bits).
- R4: The limit is bits 15:0 (low) joined with bits 51:48 (high). With granularity bit 55 clear, an offset equal to the limit passes and an offset above it gives fault code 4.
- R5: With bit 55 set, the effective limit is the 20-bit limit followed by twelve one bits. An offset above this value gives fault code 4.
- R6: With the present bit 47 clear, the fault code is 1, whatever else is wrong with the request.
- R7: Fault code 2 (type) is given in these cases: bit 44 is clear (a system segment); reserved bit 53 is set; the access kind is 3; a write to code (type bit 43 set) or to data with type bit 41 clear; an execute of data; a read of code with type bit 41 clear. Access kind codes are 0 read, 1 write, 2 execute.
- R8: When the CPL is numerically greater than the DPL in bits 46:45, the fault code is 3. A CPL equal to or below the DPL passes.
- R9: Faults are ranked in this order: not-present, then type, then privilege, then limit. Only the first failing check is reported.
- R10: On success, `rsp_desc` equals the request descriptor with bit 40 (accessed) set. On any fault, `rsp_desc` equals the request descriptor unchanged.
- R11: Bit 52 (available to software) has no effect on the fault code or the linear address.
- R12: On any fault, `rsp_linear` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_desc | input | 64 | Segment descriptor to check |
| req_offset | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_cpl | input | 2 | Current privilege level of the requester |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_fault | output | 3 | 0 none, 1 not present, 2 type, 3 privilege, 4 limit |
| rsp_linear | output | 32 | Linear address on success, zero on fault |
| rsp_desc | output | 64 | Descriptor to write back |

## Verification
A single request can break several rules in the same cycle. For example, a segment may be absent while the write targets code from a less trusted level at an offset past the limit. All four checks see the request at once, so the ranking decides what is reported. The stimulus table holds requests that stack two or more faults, such as not-present with type, privilege and limit errors, type with privilege, and privilege with limit. Each one is judged by checking that only the highest-ranked fault code comes out, that the linear address is zero and that the descriptor comes back unchanged.

// File: rtl/seg_chk_pkg.sv
// Package: shared widths, descriptor field positions, access and fault codes
// for the segment descriptor access checker.
// Assumes the descriptor uses the conventional 64-bit protected-mode layout.
package seg_chk_pkg;

    localparam int DESC_W     = 64;
    localparam int OFF_W      = 32;
    localparam int LIM_W      = 20;
    localparam int GRAN_SHIFT = OFF_W - LIM_W;
    localparam int PRIV_W     = 2;
    localparam int TYPE_W     = 4;
    localparam int FAULT_W    = 3;

    // field positions inside the descriptor
    localparam int LIM_LO_LSB  = 0;
    localparam int LIM_LO_W    = 16;
    localparam int BASE_LO_LSB = 16;
    localparam int BASE_LO_W   = 24;
    localparam int TYPE_LSB    = 40;
    localparam int ACC_BIT     = 40;
    localparam int RW_BIT      = 41;
    localparam int CODE_BIT    = 43;
    localparam int SEG_BIT     = 44;
    localparam int DPL_LSB     = 45;
    localparam int PRES_BIT    = 47;
    localparam int LIM_HI_LSB  = 48;
    localparam int LIM_HI_W    = LIM_W - LIM_LO_W;
    localparam int AVL_BIT     = 52;
    localparam int RSV_BIT     = 53;
    localparam int GRAN_BIT    = 55;
    localparam int BASE_HI_LSB = 56;
    localparam int BASE_HI_W   = OFF_W - BASE_LO_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } access_kind_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE     = 3'd0,
        FLT_ABSENT   = 3'd1,
        FLT_TYPE     = 3'd2,
        FLT_PRIV     = 3'd3,
        FLT_LIMIT    = 3'd4
    } fault_e;

    typedef struct packed {
        logic [OFF_W-1:0]  base;
        logic [LIM_W-1:0]  limit;
        logic [TYPE_W-1:0] seg_type;
        logic              code_or_data;
        logic [PRIV_W-1:0] dpl;
        logic              present;
        logic              gran;
        logic              soft_bit;
        logic              rsvd;
    } desc_fields_t;

endpackage

// File: rtl/seg_desc_unpack.sv
// Module: seg_desc_unpack
// Splits a descriptor into its fields, joins the split base and limit, and
// derives the effective byte limit from the granularity bit.
// Assumes GRAN_SHIFT + LIM_W equals the offset width (4 KB units).
module seg_desc_unpack
    import seg_chk_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output desc_fields_t      fields,
    output logic [OFF_W-1:0]  eff_limit
);

    // gather the scattered fields into one record
    always_comb begin
        fields              = '0;
        fields.base         = {desc[BASE_HI_LSB +: BASE_HI_W], desc[BASE_LO_LSB +: BASE_LO_W]};
        fields.limit        = {desc[LIM_HI_LSB +: LIM_HI_W], desc[LIM_LO_LSB +: LIM_LO_W]};
        fields.seg_type     = desc[TYPE_LSB +: TYPE_W];
        fields.code_or_data = desc[SEG_BIT];
        fields.dpl          = desc[DPL_LSB +: PRIV_W];
        fields.present      = desc[PRES_BIT];
        fields.gran         = desc[GRAN_BIT];
        fields.soft_bit     = desc[AVL_BIT];
        fields.rsvd         = desc[RSV_BIT];
    end

    // scale the limit: byte units or 4 KB units with the low bits filled
    always_comb begin
        if (fields.gran) begin
            eff_limit = {fields.limit, {GRAN_SHIFT{1'b1}}};
        end else begin
            eff_limit = {{GRAN_SHIFT{1'b0}}, fields.limit};
        end
    end

endmodule

// File: rtl/seg_rule_check.sv
// Module: seg_rule_check
// Applies presence, type, privilege and bounds rules to one access and
// returns the first failing rule in fixed rank order.
// Assumes expand-down data and system descriptors are not supported.
module seg_rule_check
    import seg_chk_pkg::*;
(
    input  desc_fields_t       fields,
    input  logic [OFF_W-1:0]   eff_limit,
    input  logic [OFF_W-1:0]   offset,
    input  access_kind_e       kind,
    input  logic [PRIV_W-1:0]  cpl,
    output fault_e             fault
);

    logic is_code;
    logic rw_ok;
    logic type_bad;
    logic priv_bad;
    logic limit_bad;

    // decide whether the segment type allows this kind of access
    always_comb begin
        is_code  = fields.seg_type[CODE_BIT - TYPE_LSB];
        rw_ok    = fields.seg_type[RW_BIT - TYPE_LSB];
        type_bad = !fields.code_or_data || fields.rsvd;
        unique case (kind)
            ACC_READ:  if (is_code && !rw_ok) type_bad = 1'b1;
            ACC_WRITE: if (is_code || !rw_ok) type_bad = 1'b1;
            ACC_EXEC:  if (!is_code)          type_bad = 1'b1;
            default:   type_bad = 1'b1;
        endcase
    end

    // privilege and bounds tests
    always_comb begin
        priv_bad  = cpl > fields.dpl;
        limit_bad = offset > eff_limit;
    end

    // rank the failures: absent, type, privilege, limit
    always_comb begin
        if (!fields.present) begin
            fault = FLT_ABSENT;
        end else if (type_bad) begin
            fault = FLT_TYPE;
        end else if (priv_bad) begin
            fault = FLT_PRIV;
        end else if (limit_bad) begin
            fault = FLT_LIMIT;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen
// Forms the linear address and the write-back descriptor for a checked
// access; both collapse to their fault forms when a fault is present.
// Assumes the address wraps modulo 2^OFF_W.
module seg_addr_gen
    import seg_chk_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [OFF_W-1:0]  base,
    input  logic [OFF_W-1:0]  offset,
    input  fault_e            fault,
    output logic [OFF_W-1:0]  linear,
    output logic [DESC_W-1:0] desc_out
);

    // add base and offset, zero the address and keep the descriptor on a fault
    always_comb begin
        desc_out = desc;
        linear   = '0;
        if (fault == FLT_NONE) begin
            linear            = base + offset;
            desc_out[ACC_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/seg_access_checker.sv
// Module: seg_access_checker
// Top level: registers a request, checks it against its descriptor and
// registers the verdict one clock later.
// Assumes a new request may arrive every cycle; no back-pressure.
module seg_access_checker
    import seg_chk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [DESC_W-1:0]   req_desc,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [1:0]          req_kind,
    input  logic [PRIV_W-1:0]   req_cpl,
    output logic                rsp_valid,
    output logic [FAULT_W-1:0]  rsp_fault,
    output logic [OFF_W-1:0]    rsp_linear,
    output logic [DESC_W-1:0]   rsp_desc
);

    logic               s1_valid;
    logic [DESC_W-1:0]  s1_desc;
    logic [OFF_W-1:0]   s1_off;
    logic [1:0]         s1_kind;
    logic [PRIV_W-1:0]  s1_cpl;

    desc_fields_t       fields;
    logic [OFF_W-1:0]   eff_limit;
    fault_e             fault;
    logic [OFF_W-1:0]   linear;
    logic [DESC_W-1:0]  desc_out;

    // capture the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_desc  <= '0;
            s1_off   <= '0;
            s1_kind  <= '0;
            s1_cpl   <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_desc <= req_desc;
                s1_off  <= req_offset;
                s1_kind <= req_kind;
                s1_cpl  <= req_cpl;
            end
        end
    end

    seg_desc_unpack u_unpack (
        .desc      (s1_desc),
        .fields    (fields),
        .eff_limit (eff_limit)
    );

    seg_rule_check u_rules (
        .fields    (fields),
        .eff_limit (eff_limit),
        .offset    (s1_off),
        .kind      (access_kind_e'(s1_kind)),
        .cpl       (s1_cpl),
        .fault     (fault)
    );

    seg_addr_gen u_addr (
        .desc     (s1_desc),
        .base     (fields.base),
        .offset   (s1_off),
        .fault    (fault),
        .linear   (linear),
        .desc_out (desc_out)
    );

    // register the verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= '0;
            rsp_linear <= '0;
            rsp_desc   <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_fault  <= fault;
                rsp_linear <= linear;
                rsp_desc   <= desc_out;
            end
        end
    end

    // R2: response follows a request two edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R6: an absent segment always reports the absent fault
    p_absent_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && !s1_desc[PRES_BIT] |=> rsp_fault == FLT_ABSENT);

    // R8: a less trusted caller on a well-formed present segment never succeeds
    p_priv_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s1_desc[PRES_BIT] && (s1_cpl > s1_desc[DPL_LSB +: PRIV_W])
        |=> rsp_fault != FLT_NONE);

    // R10: a successful response carries the accessed flag
    p_accessed_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == FLT_NONE |-> rsp_desc[ACC_BIT]);

    // R12: a faulted response carries no address
    p_zero_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != FLT_NONE |-> rsp_linear == '0);

endmodule

// File: tb/test_seg_access_checker.sv
module test_seg_access_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_desc = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_cpl = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_linear;
    logic [63:0] rsp_desc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    seg_access_checker i_seg_access_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_desc   (req_desc),
        .req_offset (req_offset),
        .req_kind   (req_kind),
        .req_cpl    (req_cpl),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_linear (rsp_linear),
        .rsp_desc   (rsp_desc)
    );

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input logic [3:0] typ, input logic s,
                                            input logic [1:0] dpl, input logic p,
                                            input logic g, input logic avl, input logic rsv);
        logic [63:0] d;
        d        = '0;
        d[15:0]  = lim[15:0];
        d[39:16] = base[23:0];
        d[43:40] = typ;
        d[44]    = s;
        d[46:45] = dpl;
        d[47]    = p;
        d[51:48] = lim[19:16];
        d[52]    = avl;
        d[53]    = rsv;
        d[55]    = g;
        d[63:56] = base[31:24];
        return d;
    endfunction

    typedef struct packed {
        logic [63:0] desc;
        logic [31:0] off;
        logic [1:0]  kind;
        logic [1:0]  cpl;
        logic [2:0]  fault;
        logic [31:0] lin;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    // type codes: 2 data rw, 0 data ro, A code exec+read, 8 code exec only, 3 data rw accessed
    localparam vec_t VECS [NV] = '{
        '{mk_desc(32'h1234_5678, 20'h00FFF, 4'h2, 1, 3, 1, 0, 0, 0), 32'h10,  2'd0, 2'd3, 3'd0, 32'h1234_5688, 4'd3},  // R3
        '{mk_desc(32'h1234_5678, 20'h00FFF, 4'h2, 1, 3, 1, 0, 0, 0), 32'hFFF, 2'd1, 2'd3, 3'd0, 32'h1234_6677, 4'd4},  // R4 at limit
        '{mk_desc(32'h1234_5678, 20'h00FFF, 4'h2, 1, 3, 1, 0, 0, 0), 32'h1000,2'd0, 2'd3, 3'd4, 32'h0, 4'd4},          // R4 past limit
        '{mk_desc(32'h8000_0000, 20'h00001, 4'h2, 1, 0, 1, 1, 0, 0), 32'h1FFF,2'd0, 2'd0, 3'd0, 32'h8000_1FFF, 4'd5},  // R5
        '{mk_desc(32'h8000_0000, 20'h00001, 4'h2, 1, 0, 1, 1, 0, 0), 32'h2000,2'd0, 2'd0, 3'd4, 32'h0, 4'd5},          // R5
        '{mk_desc(32'h0000_1000, 20'h00010, 4'h2, 1, 0, 0, 0, 0, 0), 32'h4,   2'd0, 2'd0, 3'd1, 32'h0, 4'd6},          // R6
        '{mk_desc(32'h0000_1000, 20'h00010, 4'h8, 0, 0, 0, 0, 0, 1), 32'hFFFF,2'd1, 2'd3, 3'd1, 32'h0, 4'd9},          // R9 absent wins
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'hA, 1, 0, 1, 0, 0, 0), 32'h4,   2'd1, 2'd3, 3'd2, 32'h0, 4'd9},          // R9 type over priv
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h2, 1, 3, 1, 0, 0, 0), 32'h4,   2'd2, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 exec data
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h2, 0, 3, 1, 0, 0, 0), 32'h4,   2'd0, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 system
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h8, 1, 3, 1, 0, 0, 0), 32'h4,   2'd0, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 read exec-only
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h0, 1, 3, 1, 0, 0, 0), 32'h4,   2'd1, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 write ro data
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h2, 1, 3, 1, 0, 0, 0), 32'h4,   2'd3, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 kind 3
        '{mk_desc(32'h0000_2000, 20'h000FF, 4'h2, 1, 3, 1, 0, 0, 1), 32'h4,   2'd0, 2'd3, 3'd2, 32'h0, 4'd7},          // R7 reserved bit
        '{mk_desc(32'h0000_3000, 20'h000FF, 4'h2, 1, 1, 1, 0, 0, 0), 32'h4,   2'd0, 2'd2, 3'd3, 32'h0, 4'd8},          // R8
        '{mk_desc(32'h0000_3000, 20'h000FF, 4'h2, 1, 1, 1, 0, 0, 0), 32'h400, 2'd0, 2'd2, 3'd3, 32'h0, 4'd9},          // R9 priv over limit
        '{mk_desc(32'h0000_3000, 20'h000FF, 4'h2, 1, 2, 1, 0, 0, 0), 32'h8,   2'd0, 2'd2, 3'd0, 32'h0000_3008, 4'd8},  // R8 equal
        '{mk_desc(32'hFFFF_FFF0, 20'hFFFFF, 4'hA, 1, 3, 1, 0, 0, 0), 32'h20,  2'd2, 2'd0, 3'd0, 32'h0000_0010, 4'd3},  // R3 wrap
        '{mk_desc(32'h0000_4000, 20'h000FF, 4'h3, 1, 3, 1, 0, 0, 0), 32'h1,   2'd0, 2'd3, 3'd0, 32'h0000_4001, 4'd10}, // R10 already set
        '{mk_desc(32'h0000_5000, 20'h000FF, 4'h2, 1, 3, 1, 0, 1, 0), 32'h2,   2'd1, 2'd3, 3'd0, 32'h0000_5002, 4'd11}  // R11 soft bit
    };

    task automatic check(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input vec_t v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_desc   = v.desc;
        req_offset = v.off;
        req_kind   = v.kind;
        req_cpl    = v.cpl;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin
        logic [63:0] exp_desc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("reset valid", 1, {63'b0, rsp_valid}, 64'd0);
        check("reset fault", 1, {61'b0, rsp_fault}, 64'd0);
        check("reset linear", 1, {32'b0, rsp_linear}, 64'd0);
        check("reset desc", 1, rsp_desc, 64'd0);
        rst_n = 1'b1;

        // table walk; one request in flight at a time
        for (int i = 0; i < NV; i++) begin
            send(VECS[i]);
            check("valid", 2, {63'b0, rsp_valid}, 64'd0);
            @(negedge clk);
            exp_desc = (VECS[i].fault == 3'd0) ? (VECS[i].desc | 64'h0000_0100_0000_0000) : VECS[i].desc;
            check("valid", 2, {63'b0, rsp_valid}, 64'd1);
            check("fault", int'(VECS[i].req), {61'b0, rsp_fault}, {61'b0, VECS[i].fault});
            check("linear", (VECS[i].fault == 3'd0) ? int'(VECS[i].req) : 12, {32'b0, rsp_linear}, {32'b0, VECS[i].lin});
            check("desc", 10, rsp_desc, exp_desc);
            @(negedge clk);
            check("valid drop", 2, {63'b0, rsp_valid}, 64'd0);
        end

        // R2: back-to-back requests give back-to-back responses
        @(negedge clk);
        req_valid = 1'b1; req_desc = VECS[0].desc; req_offset = 32'h20; req_kind = 2'd0; req_cpl = 2'd3;
        @(negedge clk);
        req_offset = 32'h2000;
        @(negedge clk);
        req_valid = 1'b0;
        check("b2b first", 2, {31'b0, rsp_valid, rsp_linear}, {32'd1, 32'h1234_5698});
        @(negedge clk);
        check("b2b second", 2, {60'b0, rsp_valid, rsp_fault}, {60'b0, 1'b1, 3'd4});

        // R1: reset mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("reset again", 1, {31'b0, rsp_valid, rsp_linear}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule